// File: doc/BRIEF.md
# Reset-Gated OR-Combining Register Multiplexer

This block picks one of several registered input words without any selection multiplexer after the registers. Every source has its own register. On each clock edge, only the register named by a binary select index may load. All the other registers are forced to zero by their synchronous clear. The output is the bitwise OR of every register, so it carries the chosen word one cycle after the select is applied.

The same registers also produce constant words. In constant mode the selected register ignores its data input. Each of its bits is driven by a per-bit set line and a per-bit clear line. A bit with only clear goes to 0 and a bit with only set goes to 1. A bit with neither keeps its value. A bit with both goes to 0, because clear dominates set. A global synchronous reset empties every register.

Top module: `orsel_regmux`

## Requirements
- R1: While `rst` is high at a clock edge, every source register is cleared, so `q` is zero after that edge.
- R2: In data mode (`const_mode` low), `q` after a clock edge equals the word of the source selected at that edge, as sampled at that edge.
- R3: At every edge, each source register not selected is cleared to zero, so a later selection never shows stale bits from another source.
- R4: `q` is the bitwise OR of all source registers, with no selection logic after them.
- R5: In constant mode, a selected-register bit with `const_set` high and `const_clr` low becomes 1, and a bit with `const_clr` high and `const_set` low becomes 0.
- R6: In constant mode, a bit with both `const_set` and `const_clr` high becomes 0 (clear dominates set).
- R7: In constant mode, a bit with neither line high keeps its previous value in the selected register. That value is zero if the source was not selected on the previous edge.
- R8: In constant mode, the data inputs have no effect on `q`.
- R9: Select value i (binary, 0 to NSRC-1) chooses the word at bits [i*WIDTH +: WIDTH] of `din`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Global synchronous reset, active high |
| sel | input | SELW ($clog2(NSRC)) | Binary index of the source allowed to load |
| din | input | NSRC*WIDTH | All source words, source i at [i*WIDTH +: WIDTH] |
| const_mode | input | 1 | High: the selected register takes the constant pattern instead of data |
| const_set | input | WIDTH | Per-bit set for constant mode |
| const_clr | input | WIDTH | Per-bit clear for constant mode; wins over set |
| q | output | WIDTH | OR of all source registers |

## Verification
The bench loads an all-ones word into one source and then selects a source whose input is zero. If the design failed to clear the unselected register, stale ones would leak through the OR. It drives set and clear on overlapping bit groups. If set were given priority, the overlap would read as ones instead of zeros. Hold bits are tested both on a register that was already selected and on one that was just switched to. Noisy data is driven during constant mode, so a design that still loaded data would show it. It also walks every select value with distinct words, which exposes a wrong slice offset or an off-by-one decode.

// File: rtl/orsel_regmux.sv
module orsel_regmux #(
  parameter int WIDTH = 32,
  parameter int NSRC  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [$clog2(NSRC)-1:0]  sel,
  input  logic [NSRC*WIDTH-1:0]    din,
  input  logic                     const_mode,
  input  logic [WIDTH-1:0]         const_set,
  input  logic [WIDTH-1:0]         const_clr,
  output logic [WIDTH-1:0]         q
);
  localparam int SELW = $clog2(NSRC);

  logic [NSRC-1:0]  load_en;
  logic [NSRC-1:0]  live;
  logic [WIDTH-1:0] src_q [NSRC];
  logic [WIDTH-1:0] din_sel;

  assign load_en = rst ? '0 : (NSRC'(1) << sel);
  assign din_sel = din[sel*WIDTH +: WIDTH];

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!load_en[i])
        src_q[i] <= '0;
      else if (const_mode)
        src_q[i] <= (src_q[i] | const_set) & ~const_clr;
      else
        src_q[i] <= din[i*WIDTH +: WIDTH];
    end
    assign live[i] = |src_q[i];
  end

  always_comb begin
    q = '0;
    for (int i = 0; i < NSRC; i++) q = q | src_q[i];
  end

  logic rst_d;
  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d) AST_RESET_EMPTY: assert (q == '0); // R1
  end

  AST_SINGLE_LIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(live)); // R3
  AST_UNSEL_CLEARED: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (live & ~(NSRC'(1) << $past(sel))) == '0); // R3
  AST_DATA_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !const_mode |=> q == $past(din_sel)); // R2
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
    const_mode |=> (q & $past(const_clr)) == '0); // R6
  AST_SET_ONLY: assert property (@(posedge clk) disable iff (rst)
    const_mode |=> (q & $past(const_set & ~const_clr)) == $past(const_set & ~const_clr)); // R5

  logic [SELW-1:0] unused_w;
  assign unused_w = '0;
endmodule

// File: tb/orsel_regmux_tb.sv
module orsel_regmux_tb;
  localparam int W = 32;
  localparam int N = 8;

  logic clk = 0;
  logic rst = 1;
  logic [2:0] sel = 0;
  logic [N*W-1:0] din = '0;
  logic const_mode = 0;
  logic [W-1:0] const_set = '0, const_clr = '0;
  logic [W-1:0] q;

  always #2.5 clk = ~clk;

  orsel_regmux #(.WIDTH(W), .NSRC(N)) u_dut (
    .clk(clk), .rst(rst), .sel(sel), .din(din), .const_mode(const_mode),
    .const_set(const_set), .const_clr(const_clr), .q(q));

  typedef struct { logic [W-1:0] exp; string tag; } item_t;
  item_t sb[$];
  logic [W-1:0] mdl [N];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic step(input logic r, input int s, input logic m,
                      input logic [W-1:0] st, input logic [W-1:0] cl,
                      input logic [N*W-1:0] d, input string tag);
    item_t it;
    @(negedge clk);
    rst = r; sel = 3'(s); const_mode = m; const_set = st; const_clr = cl; din = d;
    it.exp = '0;
    for (int j = 0; j < N; j++) begin
      if (r || j != s) mdl[j] = '0;
      else if (m) mdl[j] = (mdl[j] | st) & ~cl;
      else mdl[j] = d[j*W +: W];
      it.exp = it.exp | mdl[j];
    end
    it.tag = tag;
    sb.push_back(it);
  endtask

  function automatic logic [N*W-1:0] pattern(input int k);
    logic [N*W-1:0] v;
    for (int j = 0; j < N; j++) v[j*W +: W] = (32'h1111_1111 * (j + 1)) ^ (k * 32'h0101_0037);
    return v;
  endfunction

  initial begin
    forever begin
      @(posedge clk); #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        n_chk++;
        if (q !== it.exp) begin
          n_fail++;
          $display("FAIL %s: q=%h expected=%h", it.tag, q, it.exp);
        end
      end
    end
  end

  initial begin
    logic [N*W-1:0] d;
    for (int j = 0; j < N; j++) mdl[j] = '0;
    repeat (3) step(1, 0, 0, '0, '0, pattern(9), "R1 reset");
    for (int i = 0; i < N; i++) step(0, i, 0, '0, '0, pattern(i), "R2 R9 R4 walk");
    for (int i = N - 1; i >= 0; i--) step(0, i, 0, '0, '0, pattern(i + 20), "R2 R9 reverse");
    d = '0; d[0*W +: W] = '1;
    step(0, 0, 0, '0, '0, d, "R2 ones");
    step(0, 1, 0, '0, '0, d, "R3 stale clear");
    d[7*W +: W] = 32'h5;
    step(0, 7, 0, '0, '0, d, "R3 R4 single");
    step(0, 2, 1, 32'hFFFF_0000, 32'h00FF_00FF, pattern(3), "R5 R6 R7 const fresh");
    step(0, 2, 1, '0, '0, pattern(4), "R7 R8 hold");
    step(0, 2, 1, 32'h0000_F000, 32'h0000_0000, pattern(5), "R5 R8 set");
    step(0, 2, 1, '1, '1, pattern(6), "R6 both");
    d = '0; d[3*W +: W] = 32'hA5A5_A5A5;
    step(0, 3, 0, '0, '0, d, "R2 load");
    step(0, 3, 1, '0, 32'h0000_FFFF, pattern(7), "R7 hold upper");
    step(0, 3, 1, 32'h0000_000F, 32'h0000_0000, '1, "R5 R8 set low");
    step(0, 4, 0, '0, '0, pattern(8), "R2 after const");
    step(1, 4, 0, '0, '0, pattern(8), "R1 mid reset");
    step(0, 5, 0, '0, '0, pattern(10), "R2 after reset");
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: q=%h expected=finished", q);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule